// File: doc/BRIEF.md
# Boot ROM and Flash Select Decoder

This block produces the external chip selects and strobes for the boot memory of an ISA bus peripheral. It compares the top three memory address bits (SA15 to SA13) with a programmed base and a programmed window size. On a hit it asserts the select for the boot ROM. When the flash bit is set, a flash device takes the place of the ROM, and the same hit drives flash and SRAM control instead.

Two output pins change their function with the configuration. The boot-select pin is the ROM chip select, the flash output enable, or the flash chip select. The auxiliary pin carries the interrupt line when flash is off. With flash on, it is the flash write enable in bus-master mode or the SRAM chip select in shared-memory mode. The address-latch input also has two uses. Normally it is a strobe that captures the upper address bits. In chip-select mode it is instead a live active-low select for the region above bit 15.

All outputs are registered and active low, so each one reflects the inputs of the previous clock edge.

Top module: `bootsel_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, both `boot_sel_n` and `aux_pin_n` are 1 after that edge.
- R2: With `cfg_ale_cs`=0, `sa_hi` is captured at every clock edge where `ale`=1 and is held while `ale`=0. A change on `sa_hi` while `ale`=0 does not alter the match.
- R3: With `cfg_ale_cs`=0 and `cfg_flash`=0, `boot_sel_n` is 0 one cycle after an edge where `memr_n`=0 and the captured address matches. Otherwise it is 1.
- R4: With `cfg_ale_cs`=1, the match uses the live `sa_hi` and also needs `ale`=0. An edge with `ale`=1 yields `boot_sel_n`=1 in every mode.
- R5: `cfg_size` is one-hot: bit 0 selects 8 KB, bit 1 16 KB, bit 2 32 KB, bit 3 64 KB. For the window selected by bit k, the address bits `sa_hi[k-1:0]` are left out of the comparison with `cfg_match`.
- R6: A `cfg_size` value that is not one-hot never produces a hit, so `boot_sel_n` stays 1.
- R7: With `cfg_flash`=0, `aux_pin_n` equals the `irq12_n` value of the previous edge.
- R8: With `cfg_flash`=1 and `cfg_bus_master`=1, `boot_sel_n` is the flash output enable, asserted on hit with `memr_n`=0. `aux_pin_n` is the flash write enable, asserted on hit with `memw_n`=0.
- R9: With `cfg_flash`=1 and `cfg_bus_master`=0, `boot_sel_n` is the flash chip select, asserted on hit with either strobe low. `aux_pin_n` is the SRAM chip select, asserted when `sram_req`=1 with either strobe low.
- R10: With `cfg_flash`=0, a write strobe alone (`memw_n`=0, `memr_n`=1) never asserts `boot_sel_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sa_hi | input | ADDR_W | Address bits SA15..SA13 |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| ale | input | 1 | Address latch strobe, or external select in chip-select mode |
| irq12_n | input | 1 | Interrupt line routed to the auxiliary pin when flash is off |
| sram_req | input | 1 | SRAM access request in shared-memory flash mode |
| cfg_ale_cs | input | 1 | 1: address-latch input acts as an active-low chip select |
| cfg_match | input | ADDR_W | Boot window base compared with sa_hi |
| cfg_size | input | ADDR_W+1 | One-hot window size |
| cfg_flash | input | 1 | 1: flash replaces the boot ROM |
| cfg_bus_master | input | 1 | 1: bus-master mode, 0: shared-memory mode |
| boot_sel_n | output | 1 | ROM select, flash output enable, or flash chip select |
| aux_pin_n | output | 1 | Interrupt line, flash write enable, or SRAM chip select |

## Verification
Each select is due one clock edge after the strobe and address it responds to. In latch mode there is one more edge before that, when `ale` captures the address. The bench drives its inputs on the falling edge. It holds a latch cycle with `ale` high, then drives a strobe cycle in which `sa_hi` is inverted. It samples both pins at the falling edge that follows the strobe cycle, which is exactly one register stage after the inputs that decide them. The sweep covers every mode, size code, base and address with read, write and idle strobes.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;
  typedef enum logic [1:0] {
    PIN_ROM       = 2'd0,
    PIN_FLASH_BM  = 2'd1,
    PIN_FLASH_SHM = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e pick_mode(input logic flash, input logic bus_master);
    if (!flash)          return PIN_ROM;
    else if (bus_master) return PIN_FLASH_BM;
    else                 return PIN_FLASH_SHM;
  endfunction
endpackage

// File: rtl/bootsel_addr_path.sv
module bootsel_addr_path #(
  parameter int ADDR_W = 3,
  localparam int SIZE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sa_hi,
  input  logic              ale,
  input  logic              cfg_ale_cs,
  input  logic [ADDR_W-1:0] cfg_match,
  input  logic [SIZE_W-1:0] cfg_size,
  output logic              hit
);
  logic [ADDR_W-1:0] held_addr;
  logic [ADDR_W-1:0] cmp_addr;
  logic [ADDR_W-1:0] skip;
  logic              size_ok;
  logic              addr_eq;

  // address capture for latch mode
  always_ff @(posedge clk) begin
    if (rst)      held_addr <= '0;
    else if (ale) held_addr <= sa_hi;
  end

  // a bit is skipped when the selected window is wider than its granule
  for (genvar i = 0; i < ADDR_W; i++) begin : g_skip
    assign skip[i] = |cfg_size[SIZE_W-1:i+1];
  end

  assign size_ok  = (cfg_size != '0) && ((cfg_size & (cfg_size - 1'b1)) == '0);
  assign cmp_addr = cfg_ale_cs ? sa_hi : held_addr;
  assign addr_eq  = (((cmp_addr ^ cfg_match) & ~skip) == '0);

  always_comb begin
    hit = size_ok && addr_eq;
    if (cfg_ale_cs && ale) hit = 1'b0;
  end
endmodule

// File: rtl/bootsel_pin_mux.sv
module bootsel_pin_mux
  import bootsel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic memr_n,
  input  logic memw_n,
  input  logic irq12_n,
  input  logic sram_req,
  input  logic cfg_flash,
  input  logic cfg_bus_master,
  output logic boot_sel_n,
  output logic aux_pin_n
);
  pin_mode_e mode;
  logic      rd, wr;
  logic      boot_on, aux_lvl;

  assign mode = pick_mode(cfg_flash, cfg_bus_master);
  assign rd   = ~memr_n;
  assign wr   = ~memw_n;

  always_comb begin
    boot_on = 1'b0;
    aux_lvl = 1'b1;
    unique case (mode)
      PIN_ROM: begin
        boot_on = hit && rd;
        aux_lvl = irq12_n;
      end
      PIN_FLASH_BM: begin
        boot_on = hit && rd;
        aux_lvl = ~(hit && wr);
      end
      PIN_FLASH_SHM: begin
        boot_on = hit && (rd || wr);
        aux_lvl = ~(sram_req && (rd || wr));
      end
      default: begin
        boot_on = 1'b0;
        aux_lvl = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_sel_n <= 1'b1;
      aux_pin_n  <= 1'b1;
    end else begin
      boot_sel_n <= ~boot_on;
      aux_pin_n  <= aux_lvl;
    end
  end
endmodule

// File: rtl/bootsel_decoder.sv
module bootsel_decoder #(
  parameter int ADDR_W = 3,
  localparam int SIZE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sa_hi,
  input  logic              memr_n,
  input  logic              memw_n,
  input  logic              ale,
  input  logic              irq12_n,
  input  logic              sram_req,
  input  logic              cfg_ale_cs,
  input  logic [ADDR_W-1:0] cfg_match,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_flash,
  input  logic              cfg_bus_master,
  output logic              boot_sel_n,
  output logic              aux_pin_n
);
  logic hit;

  bootsel_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .sa_hi      (sa_hi),
    .ale        (ale),
    .cfg_ale_cs (cfg_ale_cs),
    .cfg_match  (cfg_match),
    .cfg_size   (cfg_size),
    .hit        (hit)
  );

  bootsel_pin_mux u_mux (
    .clk            (clk),
    .rst            (rst),
    .hit            (hit),
    .memr_n         (memr_n),
    .memw_n         (memw_n),
    .irq12_n        (irq12_n),
    .sram_req       (sram_req),
    .cfg_flash      (cfg_flash),
    .cfg_bus_master (cfg_bus_master),
    .boot_sel_n     (boot_sel_n),
    .aux_pin_n      (aux_pin_n)
  );
endmodule

// File: rtl/bootsel_decoder_checker.sv
module bootsel_decoder_checker #(
  parameter int ADDR_W = 3,
  localparam int SIZE_W = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              memr_n,
  input logic              memw_n,
  input logic              ale,
  input logic              irq12_n,
  input logic              cfg_ale_cs,
  input logic [SIZE_W-1:0] cfg_size,
  input logic              cfg_flash,
  input logic              cfg_bus_master,
  input logic              boot_sel_n,
  input logic              aux_pin_n
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (boot_sel_n && aux_pin_n));

  assert_ale_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cfg_ale_cs && ale)) |-> boot_sel_n);

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !boot_sel_n) |-> $past($onehot(cfg_size)));

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(cfg_flash)) |-> (aux_pin_n == $past(irq12_n)));

  assert_we_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cfg_flash && cfg_bus_master) && !aux_pin_n) |-> !$past(memw_n));

  assert_write_no_rom_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!cfg_flash && memr_n)) |-> boot_sel_n);
endmodule

bind bootsel_decoder bootsel_decoder_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .memr_n         (memr_n),
  .memw_n         (memw_n),
  .ale            (ale),
  .irq12_n        (irq12_n),
  .cfg_ale_cs     (cfg_ale_cs),
  .cfg_size       (cfg_size),
  .cfg_flash      (cfg_flash),
  .cfg_bus_master (cfg_bus_master),
  .boot_sel_n     (boot_sel_n),
  .aux_pin_n      (aux_pin_n)
);

// File: tb/bootsel_decoder_test.sv
module bootsel_decoder_test;
  localparam int ADDR_W = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sa_hi = '0;
  logic       memr_n = 1'b1, memw_n = 1'b1, ale = 1'b0;
  logic       irq12_n = 1'b1, sram_req = 1'b0;
  logic       cfg_ale_cs = 1'b0, cfg_flash = 1'b0, cfg_bus_master = 1'b0;
  logic [2:0] cfg_match = '0;
  logic [3:0] cfg_size = 4'd1;
  logic       boot_sel_n, aux_pin_n;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  bootsel_decoder #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .sa_hi(sa_hi), .memr_n(memr_n), .memw_n(memw_n),
    .ale(ale), .irq12_n(irq12_n), .sram_req(sram_req),
    .cfg_ale_cs(cfg_ale_cs), .cfg_match(cfg_match), .cfg_size(cfg_size),
    .cfg_flash(cfg_flash), .cfg_bus_master(cfg_bus_master),
    .boot_sel_n(boot_sel_n), .aux_pin_n(aux_pin_n)
  );

  // R5 window rule computed arithmetically
  function automatic bit window_hit(int s, int m, int a);
    int k;
    int mask;
    case (s)
      1: k = 0;
      2: k = 1;
      4: k = 2;
      8: k = 3;
      default: return 1'b0;
    endcase
    mask = (7 << k) & 7;
    return ((a ^ m) & mask) == 0;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (cs=%0b fl=%0b bm=%0b size=%0d match=%0d addr=%0d)",
               tag, act, exp, cfg_ale_cs, cfg_flash, cfg_bus_master, cfg_size, cfg_match, sa_hi);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 boot pin in reset", boot_sel_n, 1'b1);
    check("R1 aux pin in reset", aux_pin_n, 1'b1);
    rst = 1'b0;

    for (int cs = 0; cs < 2; cs++)
      for (int fl = 0; fl < 2; fl++)
        for (int bm = 0; bm < 2; bm++)
          for (int s = 0; s < 16; s++)
            for (int m = 0; m < 8; m++)
              for (int a = 0; a < 8; a++)
                for (int st = 0; st < 3; st++) begin
                  bit rd, wr, h, exp_boot, exp_aux, irqv, sreq;
                  string tb, ta;
                  // latch / setup cycle
                  cfg_ale_cs = cs[0]; cfg_flash = fl[0]; cfg_bus_master = bm[0];
                  cfg_size = s[3:0]; cfg_match = m[2:0];
                  sa_hi = a[2:0]; ale = !cs[0]; memr_n = 1'b1; memw_n = 1'b1;
                  @(negedge clk);
                  // strobe cycle; in latch mode the live address is inverted (R2)
                  rd = (st == 0); wr = (st == 1);
                  irqv = a[0] ^ st[0]; sreq = m[0];
                  ale = 1'b0;
                  sa_hi = cs[0] ? a[2:0] : ~a[2:0];
                  memr_n = !rd; memw_n = !wr;
                  irq12_n = irqv; sram_req = sreq;
                  @(negedge clk);
                  h = window_hit(s, m, a);
                  if (!fl[0]) begin
                    exp_boot = !(h && rd);
                    exp_aux  = irqv;
                    tb = wr ? "R10" : (cs[0] ? "R4" : "R2/R3");
                    ta = "R7";
                  end else if (bm[0]) begin
                    exp_boot = !(h && rd);
                    exp_aux  = !(h && wr);
                    tb = "R8"; ta = "R8";
                  end else begin
                    exp_boot = !(h && (rd || wr));
                    exp_aux  = !(sreq && (rd || wr));
                    tb = "R9"; ta = "R9";
                  end
                  if (!(s == 1 || s == 2 || s == 4 || s == 8)) tb = {tb, " R6"};
                  else if (s != 1) tb = {tb, " R5"};
                  check(tb, boot_sel_n, exp_boot);
                  check(ta, aux_pin_n, exp_aux);
                end

    // R4: ale high in chip-select mode blocks a matching read
    for (int fl = 0; fl < 2; fl++)
      for (int a = 0; a < 8; a++) begin
        cfg_ale_cs = 1'b1; cfg_flash = fl[0]; cfg_bus_master = 1'b1;
        cfg_size = 4'd1; cfg_match = a[2:0]; sa_hi = a[2:0];
        ale = 1'b1; memr_n = 1'b0; memw_n = 1'b1;
        @(negedge clk);
        check("R4 ale high blocks", boot_sel_n, 1'b1);
        ale = 1'b0;
        @(negedge clk);
        check("R4 ale low selects", boot_sel_n, 1'b0);
        memr_n = 1'b1;
        @(negedge clk);
      end

    // R1: reset mid-access returns both pins high
    cfg_ale_cs = 1'b1; cfg_flash = 1'b1; cfg_bus_master = 1'b1;
    cfg_size = 4'd8; memw_n = 1'b0; memr_n = 1'b0; ale = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 boot pin after reset", boot_sel_n, 1'b1);
    check("R1 aux pin after reset", aux_pin_n, 1'b1);
    rst = 1'b0; memw_n = 1'b1; memr_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule